// File: doc/BRIEF.md
# Asynchronous Framing Error Rate Monitor

The block sits after an asynchronous character receiver and judges how often characters arrive without a valid stop bit. It keeps the outcome of the most recent characters in a sliding history. It raises a sticky framing-error status only when the number of bad characters in the current window exceeds one. The window is eight characters in normal mode and four characters in extended-overspeed mode. A single bad character never trips the status on its own.

In synchronous (HDLC-style) mode the character history is not used. Instead, an abort-detected strobe from the upstream frame logic sets the same status bit. A separate force-set input lets a voice-receive path mark a first-low-byte event directly. The host clears the status with a write-to-clear pulse, and that pulse also empties the history. Bit sampling, character assembly and abort detection all happen upstream.

A small mode state machine tracks the operating mode. Its states are `MODE_NORM` (asynchronous, 8-character window), `MODE_OVR` (asynchronous, 4-character window) and `MODE_SYNC` (abort rule only). The synchronous select takes priority over the overspeed select. Any transition between two states flushes the history: `MODE_NORM`↔`MODE_OVR`, `MODE_NORM`↔`MODE_SYNC` and `MODE_OVR`↔`MODE_SYNC`. The machine stays in its state while the selects are unchanged.

Top module: `frame_err_mon`

## Requirements
- R1: After reset `ferr_o` is 0, the character history is empty and the mode state is `MODE_NORM`.
- R2: In normal asynchronous mode (`sync_mode_i`=0, `ovr_mode_i`=0), `ferr_o` becomes 1 when more than one of the last 8 received characters had `stop_ok_i`=0. Two bad characters that are 8 or more characters apart do not set it.
- R3: In extended-overspeed mode (`sync_mode_i`=0, `ovr_mode_i`=1), the window is the last 4 characters. Two bad characters with two good ones between them set `ferr_o`; two bad characters with three good ones between them do not.
- R4: In synchronous mode (`sync_mode_i`=1), an `abort_i` pulse sets `ferr_o`, and character strobes are neither counted nor stored.
- R5: An `abort_i` pulse in either asynchronous mode has no effect on `ferr_o`.
- R6: A `force_set_i` pulse sets `ferr_o` in any mode.
- R7: `ferr_o` is sticky until a `clear_i` pulse. The clear drops it to 0 and empties the character history, so earlier bad characters no longer count.
- R8: When a set cause and `clear_i` fall in the same cycle, `ferr_o` ends at 1. A character received in the clear cycle becomes the first entry of the fresh history.
- R9: Any change of mode state empties the history. A character received in the cycle of the change is the first entry of the new window.
- R10: `ferr_o` is registered. It reflects a strobe on the clock edge that samples the strobe.
- R11: A character with `stop_ok_i`=1 is stored as good. A cycle with `char_valid_i`=0 leaves the history unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| char_valid_i | input | 1 | One-cycle pulse: a character was received |
| stop_ok_i | input | 1 | Stop bit valid for the character, qualified by `char_valid_i` |
| ovr_mode_i | input | 1 | Extended-overspeed select (4-character window) |
| sync_mode_i | input | 1 | Synchronous/HDLC select, overrides `ovr_mode_i` |
| abort_i | input | 1 | One-cycle pulse: abort sequence detected upstream |
| force_set_i | input | 1 | One-cycle pulse: set status directly (voice first-low-byte marker) |
| clear_i | input | 1 | One-cycle host write-to-clear pulse |
| ferr_o | output | 1 | Sticky framing-error status |

## Verification
The host clear and a set cause can land in the same cycle. The set cause may be a forced set, an abort in synchronous mode, or a window-tripping character. A mode change can also coincide with a character that would otherwise complete an over-limit window. The bench drives these coincidences directly: a clear together with a force, and a switch from normal to overspeed mode together with a second bad character. A random phase then mixes the strobes freely. Each cycle is judged against a bench model that applies the stated rules in order: flush on clear or mode change, then shift, then count, then set-over-clear.

// File: rtl/fem_pkg.sv
package fem_pkg;
    typedef enum logic [1:0] {
        MODE_NORM = 2'd0,
        MODE_OVR  = 2'd1,
        MODE_SYNC = 2'd2
    } fem_mode_e;
endpackage

// File: rtl/fem_mode_fsm.sv
module fem_mode_fsm
    import fem_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      ovr_sel,
    input  logic      sync_sel,
    output fem_mode_e mode_now,
    output logic      mode_flush
);
    fem_mode_e state_q, state_d;

    always_comb begin
        unique case ({sync_sel, ovr_sel})
            2'b00:   state_d = MODE_NORM;
            2'b01:   state_d = MODE_OVR;
            default: state_d = MODE_SYNC;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_NORM;
        else        state_q <= state_d;
    end

    always_comb begin
        mode_now   = state_d;
        mode_flush = (state_d != state_q);
    end

    // R1
    reset_mode_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> state_q == MODE_NORM);

    // R9
    mode_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_flush |=> state_q == $past(mode_now));
endmodule

// File: rtl/fem_window.sv
module fem_window #(
    parameter int WIN_LONG  = 8,
    parameter int WIN_SHORT = 4,
    parameter int BAD_LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic shift_en,
    input  logic bad_char,
    input  logic short_win,
    output logic over_limit
);
    localparam int CNT_W = $clog2(WIN_LONG + 1);
    localparam logic [WIN_LONG-1:0] SHORT_MASK =
        {{(WIN_LONG-WIN_SHORT){1'b0}}, {WIN_SHORT{1'b1}}};

    logic [WIN_LONG-1:0] hist_q, hist_d, masked;
    logic [CNT_W-1:0]    bad_cnt;

    always_comb begin
        hist_d = flush ? '0 : hist_q;
        if (shift_en) hist_d = {hist_d[WIN_LONG-2:0], bad_char};
        masked  = short_win ? (hist_d & SHORT_MASK) : hist_d;
        bad_cnt = '0;
        for (int i = 0; i < WIN_LONG; i++)
            bad_cnt = bad_cnt + {{(CNT_W-1){1'b0}}, masked[i]};
        over_limit = bad_cnt > CNT_W'(BAD_LIMIT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    // R7
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> $countones(hist_q) <= 1);

    // R11
    hist_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !flush) |=> $stable(hist_q));
endmodule

// File: rtl/fem_status.sv
module fem_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clear_i,
    output logic ferr_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ferr_o <= 1'b0;
        else if (set_i)   ferr_o <= 1'b1;
        else if (clear_i) ferr_o <= 1'b0;
    end

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ferr_o && !clear_i) |=> ferr_o);

    // R8
    set_over_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> ferr_o);

    // R7
    clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !set_i) |=> !ferr_o);

    // R10
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ferr_o) |-> $past(set_i));
endmodule

// File: rtl/frame_err_mon.sv
module frame_err_mon
    import fem_pkg::*;
#(
    parameter int WIN_LONG  = 8,
    parameter int WIN_SHORT = 4,
    parameter int BAD_LIMIT = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic char_valid_i,
    input  logic stop_ok_i,
    input  logic ovr_mode_i,
    input  logic sync_mode_i,
    input  logic abort_i,
    input  logic force_set_i,
    input  logic clear_i,
    output logic ferr_o
);
    fem_mode_e mode_now;
    logic mode_flush, is_sync, shift_en, over_limit, set_any;

    fem_mode_fsm u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .ovr_sel   (ovr_mode_i),
        .sync_sel  (sync_mode_i),
        .mode_now  (mode_now),
        .mode_flush(mode_flush)
    );

    always_comb begin
        is_sync  = (mode_now == MODE_SYNC);
        shift_en = char_valid_i && !is_sync;
    end

    fem_window #(
        .WIN_LONG (WIN_LONG),
        .WIN_SHORT(WIN_SHORT),
        .BAD_LIMIT(BAD_LIMIT)
    ) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (mode_flush || clear_i),
        .shift_en  (shift_en),
        .bad_char  (!stop_ok_i),
        .short_win (mode_now == MODE_OVR),
        .over_limit(over_limit)
    );

    always_comb
        set_any = force_set_i || (abort_i && is_sync) || (shift_en && over_limit);

    fem_status u_stat (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_any),
        .clear_i(clear_i),
        .ferr_o (ferr_o)
    );

    // R4
    sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_mode_i && abort_i) |=> ferr_o);

    // R6
    force_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_set_i |=> ferr_o);

    // R5
    async_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode_i && abort_i && !char_valid_i && !force_set_i && !ferr_o) |=> !ferr_o);
endmodule

// File: tb/frame_err_mon_tb.sv
`timescale 1ns/1ps
module frame_err_mon_tb_top;
    logic clk = 0, rst_n = 0;
    logic cv = 0, ok = 1, ovr = 0, syn = 0, ab = 0, fs = 0, clr = 0;
    logic ferr;
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [7:0] m_hist = '0;
    int         m_mode = 0;
    logic       m_ferr = 0;

    always #2 clk = ~clk;

    frame_err_mon dut_i (
        .clk(clk), .rst_n(rst_n), .char_valid_i(cv), .stop_ok_i(ok),
        .ovr_mode_i(ovr), .sync_mode_i(syn), .abort_i(ab),
        .force_set_i(fs), .clear_i(clr), .ferr_o(ferr)
    );

    function automatic int pop(input logic [7:0] v);
        int c = 0;
        for (int i = 0; i < 8; i++) c += v[i];
        return c;
    endfunction

    task automatic model_step();
        int nm = syn ? 2 : (ovr ? 1 : 0);
        logic [7:0] h = ((nm != m_mode) || clr) ? 8'h00 : m_hist;
        logic set = fs || (ab && nm == 2);
        if (cv && nm != 2) begin
            h = {h[6:0], !ok};
            if (pop(nm == 1 ? (h & 8'h0F) : h) > 1) set = 1;
        end
        m_ferr = set ? 1'b1 : (clr ? 1'b0 : m_ferr);
        m_hist = h;
        m_mode = nm;
    endtask

    task automatic check(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: ferr_o=%0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // drive one cycle of inputs at negedge, compare after the sampling edge
    task automatic cyc(input logic c, input logic o, input logic a, input logic f,
                       input logic cl, input string req);
        cv = c; ok = o; ab = a; fs = f; clr = cl;
        model_step();
        @(posedge clk);
        @(negedge clk);
        cv = 0; ok = 1; ab = 0; fs = 0; clr = 0;
        check(ferr, m_ferr, req);
    endtask

    task automatic good(input int n, input string req);
        for (int i = 0; i < n; i++) cyc(1, 1, 0, 0, 0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(ferr, 1'b0, "R1 reset");

        // R2: bad chars 8 apart stay clear, 7 apart trip
        cyc(1, 0, 0, 0, 0, "R2"); good(7, "R2");
        cyc(1, 0, 0, 0, 0, "R2 boundary");
        check(ferr, 1'b0, "R2 outside window");
        good(6, "R2 one bad");
        cyc(1, 0, 0, 0, 0, "R2");
        check(ferr, 1'b1, "R2 two in eight");
        // R7: sticky, clear flushes history
        good(3, "R7 sticky");
        check(ferr, 1'b1, "R7 sticky");
        cyc(0, 1, 0, 0, 1, "R7 clear");
        check(ferr, 1'b0, "R7 cleared");
        cyc(1, 0, 0, 0, 0, "R7 flushed history");
        check(ferr, 1'b0, "R7 history flushed");
        // R11: idle cycles keep history
        repeat (5) cyc(0, 0, 0, 0, 0, "R11 idle");
        cyc(1, 0, 0, 0, 0, "R11");
        check(ferr, 1'b1, "R11 history kept across idle");
        cyc(0, 1, 0, 0, 1, "R7");

        // R3: overspeed window of 4
        ovr = 1;
        cyc(1, 0, 0, 0, 0, "R3"); good(3, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        check(ferr, 1'b0, "R3 outside window");
        good(2, "R3");
        cyc(1, 0, 0, 0, 0, "R3");
        check(ferr, 1'b1, "R3 two in four");
        cyc(0, 1, 0, 0, 1, "R7");

        // R5: abort ignored in async
        cyc(0, 1, 1, 0, 0, "R5");
        check(ferr, 1'b0, "R5 async abort");

        // R9: mode change with a bad char flushes
        ovr = 0;
        cyc(1, 0, 0, 0, 0, "R9 setup");
        ovr = 1;
        cyc(1, 0, 0, 0, 0, "R9");
        check(ferr, 1'b0, "R9 flush on mode change");
        ovr = 0;

        // R4: sync mode
        syn = 1;
        repeat (6) cyc(1, 0, 0, 0, 0, "R4 chars ignored");
        check(ferr, 1'b0, "R4 chars not counted");
        cyc(0, 1, 1, 0, 0, "R4");
        check(ferr, 1'b1, "R4 abort sets");
        // R8: clear with abort, set wins
        cyc(0, 1, 1, 0, 1, "R8");
        check(ferr, 1'b1, "R8 abort beats clear");
        cyc(0, 1, 0, 0, 1, "R7");
        syn = 0;

        // R6 and R8 with force
        cyc(0, 1, 0, 1, 0, "R6");
        check(ferr, 1'b1, "R6 force");
        cyc(0, 1, 0, 1, 1, "R8");
        check(ferr, 1'b1, "R8 force beats clear");
        cyc(1, 0, 0, 0, 1, "R8 char in clear cycle");
        check(ferr, 1'b0, "R8 cleared");
        cyc(1, 0, 0, 0, 0, "R8");
        check(ferr, 1'b1, "R8 clear-cycle char kept");

        // R10: random mix, checked each cycle
        for (int k = 0; k < 4000; k++) begin
            if ($urandom_range(0, 49) == 0) ovr = $urandom_range(0, 1);
            if ($urandom_range(0, 79) == 0) syn = $urandom_range(0, 1);
            cyc($urandom_range(0, 2) != 0, $urandom_range(0, 5) != 0,
                $urandom_range(0, 29) == 0, $urandom_range(0, 99) == 0,
                $urandom_range(0, 11) == 0, "R10 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule